// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block collects interrupt sources for a small multiprocessor cluster of up to eight CPUs and decides, for each CPU, which interrupt that CPU should take next. It holds per-source enable, trigger mode, priority and CPU routing state behind a 32-bit word-addressed register port. The number of interrupt lines is set in groups of 32. IDs 0 to 15 are software interrupts. IDs 16 to 31 are per-CPU private lines. IDs 32 and up are shared lines that can be routed to any set of CPUs.

Enable and pending state for IDs 0 to 31 exists once per CPU. Each register access carries the number of the requesting CPU, and that number selects which copy is read or written. Every source is either edge-captured or level-sensitive. A software-interrupt register makes a chosen software ID pending on a list of CPUs.

For each CPU the block presents one request, made up of a valid flag, the winning ID and its priority, or no request at all. A single global enable bit gates all forwarding. Acknowledge from a CPU interface arrives as an ID and a CPU number and clears a captured edge.

Top module: `idist_top`

## Requirements
- R1: After reset the global enable, every enable bit, every priority and every shared target byte read as 0, and no CPU has a request.
- R2: The read-only word at byte address 0x004 returns LINE_WORDS-1 in bits 4:0, which is (value+1)*32 lines, with all other bits 0.
- R3: Enable word k lives at 0x100+4k (set view) and at 0x180+4k (clear view), one bit per ID with bit id%32 in word id/32. A 1 written to the set view enables the ID, a 1 written to the clear view disables it, 0 bits change nothing, and both views read the current enables.
- R4: For IDs 0 to 31 the enable word (k=0) and the pending word (k=0) are held separately for each CPU, and reg_cpu selects the copy. Shared enable and pending words are the same for all CPUs.
- R5: Trigger mode uses word 0xC00+4*(id/16). Bit 2*(id%16)+1 is 1 for edge and 0 for level, and the even bits read 0. IDs 0 to 15 always read as edge (pattern 0xAAAAAAAA in word 0) and ignore writes. Other IDs reset to level.
- R6: Priorities are 8 bits at 0x400+4*(id/4), byte lane id%4. Targets use the same layout at 0x800, and bit n of a byte routes the ID to CPU n. Target bits at or above NUM_CPUS read 0. Target bytes for IDs 0 to 31 read as the one-hot code of the requesting CPU and ignore writes.
- R7: An edge source becomes pending on a rising input and stays pending until acknowledged by ack_valid with ack_id (and ack_cpu for IDs below 32). A level source is pending exactly while its input is high, and acknowledge has no effect on it.
- R8: Bit 0 of the word at 0x000 is the global enable. While it is 0, no CPU has a request, and pending state is kept.
- R9: A write to 0xF00 makes the ID in bits 3:0 pending on every CPU n whose bit 16+n is set.
- R10: A CPU's request covers IDs that are pending, enabled and routed to it (IDs 0 to 31 are always routed to their own CPU). The smallest priority value wins, and ties go to the lowest ID. req_prio carries the winner's priority.
- R11: When a new edge or a software-interrupt set and an acknowledge of the same pending bit fall in the same cycle, the bit ends up pending.
- R12: Pending word k can be read at 0x200+4k, using the same bit layout as the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_cpu | input | CPU_W | Number of the CPU making the access |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as the access |
| ppi_in | input | NUM_CPUS*16 | Private lines, bit n*16+j is ID 16+j of CPU n |
| spi_in | input | NUM_IDS-32 | Shared lines, bit s is ID 32+s |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W | CPU giving the acknowledge |
| ack_id | input | ID_W | ID being acknowledged |
| req_valid | output | NUM_CPUS | Request present, one bit per CPU |
| req_id | output | NUM_CPUS*ID_W | Winning ID per CPU |
| req_prio | output | NUM_CPUS*8 | Winning priority per CPU |

## Verification
Two events can land on the same pending bit in one cycle: a capture (a rising edge on a shared line, or a software-interrupt write) and an acknowledge of that same bit. The bench provokes both cases by driving the acknowledge strobe in the same clock low phase as the line rise or the register write. It then reads the pending word through the register port, where the bit must still be set, and follows with a lone acknowledge that must clear it. A second overlap occurs inside the selection logic, where two candidates share a priority. There the lower ID must be the one presented.

// File: rtl/idist_pkg.sv
package idist_pkg;

  localparam int unsigned PRIO_W = 8;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_ENSET, RG_ENCLR,
    RG_PEND, RG_PRIO, RG_TGT, RG_CFG, RG_SGI
  } region_e;

  // Which register window a byte address falls in.
  function automatic region_e region_of(input logic [11:0] a);
    region_e r;
    r = RG_NONE;
    if (a[1:0] == 2'b00) begin
      case (a[11:8])
        4'h0: begin
          if (a[7:2] == 6'd0) r = RG_CTRL;
          else if (a[7:2] == 6'd1) r = RG_TYPE;
        end
        4'h1: r = a[7] ? RG_ENCLR : RG_ENSET;
        4'h2: if (!a[7]) r = RG_PEND;
        4'h4, 4'h5, 4'h6, 4'h7: r = RG_PRIO;
        4'h8, 4'h9, 4'hA, 4'hB: r = RG_TGT;
        4'hC: r = RG_CFG;
        4'hF: if (a[7:2] == 6'd0) r = RG_SGI;
        default: r = RG_NONE;
      endcase
    end
    return r;
  endfunction

  // Word index inside the window.
  function automatic int unsigned word_of(input logic [11:0] a, input region_e r);
    case (r)
      RG_ENSET, RG_ENCLR, RG_PEND: return int'(a[6:2]);
      RG_PRIO, RG_TGT:             return int'(a[9:2]);
      RG_CFG:                      return int'(a[7:2]);
      default:                     return 0;
    endcase
  endfunction

  function automatic int unsigned byte_word(input int unsigned id); return id / 4; endfunction
  function automatic int unsigned byte_lane(input int unsigned id); return id % 4; endfunction
  function automatic int unsigned cfg_word(input int unsigned id); return id / 16; endfunction
  function automatic int unsigned cfg_bit(input int unsigned id); return 2 * (id % 16) + 1; endfunction
  function automatic int unsigned en_word(input int unsigned id); return id / 32; endfunction
  function automatic int unsigned en_bit(input int unsigned id); return id % 32; endfunction

endpackage

// File: rtl/idist_pend_bank.sv
module idist_pend_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] set_sw,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q, lat_q, rise;

  assign rise = lvl_in & ~prev_q;

  // A capture and a clear in the same cycle leave the bit set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= lvl_in;
      lat_q  <= edge_mode & ((lat_q & ~clr) | rise | set_sw);
    end
  end

  assign pend = (edge_mode & lat_q) | (~edge_mode & lvl_in);
endmodule

// File: rtl/idist_pick.sv
module idist_pick #(
  parameter int unsigned N    = 64,
  parameter int unsigned ID_W = 6
) (
  input  logic [N-1:0]   cand,
  input  logic [N*8-1:0] prio_flat,
  output logic           valid,
  output logic [ID_W-1:0] id,
  output logic [7:0]     prio
);
  // Smallest value wins; strict compare keeps the lowest ID on ties.
  always_comb begin
    valid = 1'b0;
    id    = '0;
    prio  = 8'hFF;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!valid || prio_flat[i*8 +: 8] < prio)) begin
        valid = 1'b1;
        id    = ID_W'(i);
        prio  = prio_flat[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/idist_top.sv
module idist_top
  import idist_pkg::*;
#(
  parameter int unsigned NUM_CPUS   = 2,
  parameter int unsigned LINE_WORDS = 2,
  localparam int unsigned NUM_IDS = LINE_WORDS * 32,
  localparam int unsigned NUM_SH  = NUM_IDS - 32,
  localparam int unsigned CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int unsigned ID_W    = $clog2(NUM_IDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_sel,
  input  logic                     reg_wr,
  input  logic [CPU_W-1:0]         reg_cpu,
  input  logic [11:0]              reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [NUM_CPUS*16-1:0]   ppi_in,
  input  logic [NUM_SH-1:0]        spi_in,
  input  logic                     ack_valid,
  input  logic [CPU_W-1:0]         ack_cpu,
  input  logic [ID_W-1:0]          ack_id,
  output logic [NUM_CPUS-1:0]      req_valid,
  output logic [NUM_CPUS*ID_W-1:0] req_id,
  output logic [NUM_CPUS*8-1:0]    req_prio
);
  // ---- state
  logic                glb_en;
  logic [PRIO_W-1:0]   prio_q [NUM_IDS];
  logic [NUM_CPUS-1:0] tgt_q  [NUM_SH];
  logic [NUM_IDS-17:0] cfg_hi_q;          // edge flag for IDs 16 and up
  logic [31:0]         en_pv_q [NUM_CPUS];
  logic [NUM_SH-1:0]   en_sh_q;
  logic [31:0]         pend_pv [NUM_CPUS];
  logic [NUM_SH-1:0]   pend_sh;

  // ---- named access events
  region_e     rg;
  int unsigned wdw;
  logic        acc_wr, acc_rd, sgi_wr, enset0_wr, enclr0_wr;

  assign rg        = region_of(reg_addr);
  assign wdw       = word_of(reg_addr, rg);
  assign acc_wr    = reg_sel & reg_wr;
  assign acc_rd    = reg_sel & ~reg_wr;
  assign sgi_wr    = acc_wr && (rg == RG_SGI);
  assign enset0_wr = acc_wr && (rg == RG_ENSET) && (wdw == 0);
  assign enclr0_wr = acc_wr && (rg == RG_ENCLR) && (wdw == 0);

  // ---- register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en   <= 1'b0;
      cfg_hi_q <= '0;
      en_sh_q  <= '0;
      for (int i = 0; i < NUM_IDS; i++) prio_q[i] <= '0;
      for (int s = 0; s < NUM_SH; s++) tgt_q[s] <= '0;
      for (int n = 0; n < NUM_CPUS; n++) en_pv_q[n] <= '0;
    end else if (acc_wr) begin
      if (rg == RG_CTRL) glb_en <= reg_wdata[0];
      for (int i = 0; i < NUM_IDS; i++)
        if (rg == RG_PRIO && wdw == byte_word(i))
          prio_q[i] <= reg_wdata[8*byte_lane(i) +: 8];
      for (int s = 0; s < NUM_SH; s++) begin
        if (rg == RG_TGT && wdw == byte_word(s + 32))
          tgt_q[s] <= reg_wdata[8*byte_lane(s + 32) +: NUM_CPUS];
        if (rg == RG_ENSET && wdw == en_word(s + 32) && reg_wdata[en_bit(s + 32)])
          en_sh_q[s] <= 1'b1;
        if (rg == RG_ENCLR && wdw == en_word(s + 32) && reg_wdata[en_bit(s + 32)])
          en_sh_q[s] <= 1'b0;
      end
      for (int j = 0; j < NUM_IDS - 16; j++)
        if (rg == RG_CFG && wdw == cfg_word(j + 16))
          cfg_hi_q[j] <= reg_wdata[cfg_bit(j + 16)];
      for (int n = 0; n < NUM_CPUS; n++)
        if (reg_cpu == CPU_W'(n)) begin
          if (enset0_wr) en_pv_q[n] <= en_pv_q[n] | reg_wdata;
          if (enclr0_wr) en_pv_q[n] <= en_pv_q[n] & ~reg_wdata;
        end
    end
  end

  // ---- register reads
  logic [31:0] rd_mux;
  logic [7:0]  self_hot;
  assign self_hot = 8'd1 << reg_cpu;

  always_comb begin
    rd_mux = '0;
    case (rg)
      RG_CTRL: rd_mux[0] = glb_en;
      RG_TYPE: rd_mux[4:0] = 5'(LINE_WORDS - 1);
      RG_ENSET, RG_ENCLR, RG_PEND: begin
        for (int n = 0; n < NUM_CPUS; n++)
          if (wdw == 0 && reg_cpu == CPU_W'(n))
            rd_mux = (rg == RG_PEND) ? pend_pv[n] : en_pv_q[n];
        for (int k = 1; k < LINE_WORDS; k++)
          if (wdw == k)
            rd_mux = (rg == RG_PEND) ? pend_sh[(k-1)*32 +: 32] : en_sh_q[(k-1)*32 +: 32];
      end
      RG_PRIO:
        for (int i = 0; i < NUM_IDS; i++)
          if (wdw == byte_word(i)) rd_mux[8*byte_lane(i) +: 8] = prio_q[i];
      RG_TGT: begin
        for (int i = 0; i < 32; i++)
          if (wdw == byte_word(i)) rd_mux[8*byte_lane(i) +: 8] = self_hot;
        for (int s = 0; s < NUM_SH; s++)
          if (wdw == byte_word(s + 32)) rd_mux[8*byte_lane(s + 32) +: 8] = 8'(tgt_q[s]);
      end
      RG_CFG: begin
        for (int i = 0; i < 16; i++)
          if (wdw == cfg_word(i)) rd_mux[cfg_bit(i)] = 1'b1;
        for (int j = 0; j < NUM_IDS - 16; j++)
          if (wdw == cfg_word(j + 16)) rd_mux[cfg_bit(j + 16)] = cfg_hi_q[j];
      end
      default: rd_mux = '0;
    endcase
  end

  assign reg_rdata = acc_rd ? rd_mux : '0;

  // ---- pending capture
  logic                      ack_is_pv;
  logic [31:0]               sgi_set    [NUM_CPUS];
  logic [31:0]               ack_clr_pv [NUM_CPUS];
  logic [NUM_SH-1:0]         ack_clr_sh;
  logic [NUM_IDS-1:0]        cand       [NUM_CPUS];
  logic [NUM_IDS*8-1:0]      prio_flat;
  logic [NUM_CPUS*32-1:0]    en_pv_flat, pend_pv_flat;
  logic [NUM_CPUS*NUM_IDS-1:0] cand_flat;

  assign ack_is_pv = ack_valid && (ack_id < ID_W'(32));

  genvar n, i, s;
  generate
    for (s = 0; s < NUM_SH; s++) begin : g_sh
      assign ack_clr_sh[s] = ack_valid && (ack_id == ID_W'(s + 32));
    end
    idist_pend_bank #(.W(NUM_SH)) u_pend_sh (
      .clk(clk), .rst_n(rst_n), .lvl_in(spi_in),
      .edge_mode(cfg_hi_q[NUM_IDS-17:16]), .set_sw('0),
      .clr(ack_clr_sh), .pend(pend_sh)
    );
    for (i = 0; i < NUM_IDS; i++) begin : g_pf
      assign prio_flat[i*8 +: 8] = prio_q[i];
    end
    for (n = 0; n < NUM_CPUS; n++) begin : g_cpu
      assign sgi_set[n]    = (sgi_wr && reg_wdata[16+n]) ? (32'd1 << reg_wdata[3:0]) : '0;
      assign ack_clr_pv[n] = (ack_is_pv && ack_cpu == CPU_W'(n)) ? (32'd1 << ack_id[4:0]) : '0;
      idist_pend_bank #(.W(32)) u_pend_pv (
        .clk(clk), .rst_n(rst_n), .lvl_in({ppi_in[n*16 +: 16], 16'h0000}),
        .edge_mode({cfg_hi_q[15:0], 16'hFFFF}), .set_sw(sgi_set[n]),
        .clr(ack_clr_pv[n]), .pend(pend_pv[n])
      );
      for (i = 0; i < 32; i++) begin : g_pv
        assign cand[n][i] = glb_en & pend_pv[n][i] & en_pv_q[n][i];
      end
      for (s = 0; s < NUM_SH; s++) begin : g_sv
        assign cand[n][s+32] = glb_en & pend_sh[s] & en_sh_q[s] & tgt_q[s][n];
      end
      assign en_pv_flat[n*32 +: 32]          = en_pv_q[n];
      assign pend_pv_flat[n*32 +: 32]        = pend_pv[n];
      assign cand_flat[n*NUM_IDS +: NUM_IDS] = cand[n];
      idist_pick #(.N(NUM_IDS), .ID_W(ID_W)) u_pick (
        .cand(cand[n]), .prio_flat(prio_flat), .valid(req_valid[n]),
        .id(req_id[n*ID_W +: ID_W]), .prio(req_prio[n*8 +: 8])
      );
    end
  endgenerate
endmodule

// File: rtl/idist_checker.sv
module idist_checker #(
  parameter int unsigned NUM_CPUS = 2,
  parameter int unsigned NUM_IDS  = 64,
  parameter int unsigned ID_W     = 6,
  parameter int unsigned CPU_W    = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [31:0]                 reg_wdata,
  input logic [CPU_W-1:0]            reg_cpu,
  input logic                        glb_en,
  input logic                        enset0_wr,
  input logic                        enclr0_wr,
  input logic                        sgi_wr,
  input logic [NUM_CPUS*32-1:0]      en_pv_flat,
  input logic [NUM_CPUS*32-1:0]      pend_pv_flat,
  input logic [NUM_CPUS*NUM_IDS-1:0] cand_flat,
  input logic [NUM_CPUS-1:0]         req_valid,
  input logic [NUM_CPUS*ID_W-1:0]    req_id
);
  // R8: forwarding is off while the global enable is clear
  p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (req_valid == '0));

  genvar n;
  generate
    for (n = 0; n < NUM_CPUS; n++) begin : g_c
      // R3: bits written to the set view are enabled next cycle
      p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enset0_wr && reg_cpu == CPU_W'(n)) |=>
          ((en_pv_flat[n*32 +: 32] & $past(reg_wdata)) == $past(reg_wdata)));
      // R3: bits written to the clear view are disabled next cycle
      p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enclr0_wr && reg_cpu == CPU_W'(n)) |=>
          ((en_pv_flat[n*32 +: 32] & $past(reg_wdata)) == 32'd0));
      // R9: a listed CPU sees the software ID pending next cycle
      p_sgi_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sgi_wr && reg_wdata[16+n]) |=>
          (((pend_pv_flat[n*32 +: 16] >> $past(reg_wdata[3:0])) & 16'd1) == 16'd1));
      // R10: a presented ID is always a live candidate of that CPU
      p_req_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[n] |->
          (((cand_flat[n*NUM_IDS +: NUM_IDS] >> req_id[n*ID_W +: ID_W]) & NUM_IDS'(1)) != '0));
    end
  endgenerate
endmodule

bind idist_top idist_checker #(
  .NUM_CPUS(NUM_CPUS), .NUM_IDS(NUM_IDS), .ID_W(ID_W), .CPU_W(CPU_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wdata(reg_wdata), .reg_cpu(reg_cpu),
  .glb_en(glb_en), .enset0_wr(enset0_wr), .enclr0_wr(enclr0_wr), .sgi_wr(sgi_wr),
  .en_pv_flat(en_pv_flat), .pend_pv_flat(pend_pv_flat), .cand_flat(cand_flat),
  .req_valid(req_valid), .req_id(req_id)
);

// File: tb/tb_idist_top.sv
module tb_idist_top;
  localparam int NC = 2;
  localparam int LW = 2;
  localparam int NI = LW * 32;
  localparam int NS = NI - 32;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [0:0] reg_cpu = '0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NC*16-1:0] ppi = '0;
  logic [NS-1:0] spi = '0;
  logic ack_valid = 1'b0;
  logic [0:0] ack_cpu = '0;
  logic [IW-1:0] ack_id = '0;
  logic [NC-1:0] req_valid;
  logic [NC*IW-1:0] req_id;
  logic [NC*8-1:0] req_prio;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  idist_top #(.NUM_CPUS(NC), .LINE_WORDS(LW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_cpu(reg_cpu),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ppi_in(ppi), .spi_in(spi), .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_id(ack_id),
    .req_valid(req_valid), .req_id(req_id), .req_prio(req_prio)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; spi = '0; ppi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_cpu = 1'(cpu); reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_cpu = 1'(cpu); reg_addr = a;
    #1 d = reg_rdata;
    #1 reg_sel = 1'b0;
  endtask

  task automatic rdchk(input string tag, input int cpu, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(cpu, a, d);
    chk(tag, d, exp);
  endtask

  task automatic ack(input int cpu, input int id);
    @(negedge clk);
    ack_valid = 1'b1; ack_cpu = 1'(cpu); ack_id = IW'(id);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic chk_req(input string tag, input int n, input bit v, input int id, input int p);
    chk({tag, " valid"}, 32'(req_valid[n]), 32'(v));
    if (v) begin
      chk({tag, " id"}, 32'(req_id[n*IW +: IW]), 32'(id));
      chk({tag, " prio"}, 32'(req_prio[n*8 +: 8]), 32'(p));
    end
  endtask

  function automatic logic [7:0] pbyte(input int id);
    return 8'((id * 37 + 5) & 255);
  endfunction

  initial begin
    logic [31:0] e, d;
    do_reset();

    // ---------------- reset state
    rdchk("R1 ctrl", 0, 12'h000, 32'h0);
    rdchk("R2 type", 1, 12'h004, 32'(LW - 1));
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < LW; k++) begin
        rdchk("R1 enable", c, 12'(12'h100 + 4*k), 32'h0);
        rdchk("R1 pending", c, 12'(12'h200 + 4*k), 32'h0);
      end
    for (int w = 0; w < NI/4; w++) begin
      rdchk("R1 prio", 0, 12'(12'h400 + 4*w), 32'h0);
      for (int c = 0; c < NC; c++)
        rdchk("R1/R6 target", c, 12'(12'h800 + 4*w), (w < 8) ? (32'h01010101 << c) : 32'h0);
    end
    rdchk("R5 cfg word0 reset", 0, 12'hC00, 32'hAAAAAAAA);
    for (int w = 1; w < NI/16; w++) rdchk("R5 cfg reset", 0, 12'(12'hC00 + 4*w), 32'h0);
    chk("R1 no request", 32'(req_valid), 32'h0);

    // ---------------- priority sweep
    for (int w = 0; w < NI/4; w++)
      wr(w % NC, 12'(12'h400 + 4*w),
         {pbyte(4*w+3), pbyte(4*w+2), pbyte(4*w+1), pbyte(4*w)});
    for (int w = 0; w < NI/4; w++)
      rdchk("R6 prio sweep", (w + 1) % NC, 12'(12'h400 + 4*w),
            {pbyte(4*w+3), pbyte(4*w+2), pbyte(4*w+1), pbyte(4*w)});

    // ---------------- target sweep
    for (int w = 0; w < NI/4; w++) begin
      d = 32'h9C5A3E71 ^ (32'(w) * 32'h01030507);
      wr(0, 12'(12'h800 + 4*w), d);
      e = (w < 8) ? 32'h02020202 : (d & 32'h03030303);
      rdchk("R6 target sweep", 1, 12'(12'h800 + 4*w), e);
    end

    // ---------------- config sweep
    for (int w = 0; w < NI/16; w++) begin
      d = (w == 0) ? 32'h55555555 : (32'h12345678 ^ (32'(w) * 32'h0F1E2D3C));
      wr(0, 12'(12'hC00 + 4*w), d);
      e = (w == 0) ? 32'hAAAAAAAA : (d & 32'hAAAAAAAA);
      rdchk("R5 cfg sweep", 1, 12'(12'hC00 + 4*w), e);
    end

    // ---------------- enable aliases and banking
    wr(0, 12'h100, 32'h12345678);
    rdchk("R3 set view", 0, 12'h100, 32'h12345678);
    rdchk("R3 clear view", 0, 12'h180, 32'h12345678);
    rdchk("R4 other cpu bank", 1, 12'h180, 32'h0);
    wr(0, 12'h180, 32'h0);
    rdchk("R3 zero write no effect", 0, 12'h100, 32'h12345678);
    wr(0, 12'h180, 32'h00000070);
    rdchk("R3 clear bits", 0, 12'h100, 32'h12345608);
    wr(1, 12'h104, 32'hF0F0F0F0);
    rdchk("R4 shared seen by cpu0", 0, 12'h104, 32'hF0F0F0F0);
    wr(0, 12'h184, 32'h000000F0);
    rdchk("R3 shared clear", 1, 12'h184, 32'hF0F0F000);

    // ---------------- functional section
    do_reset();
    wr(0, 12'hC08, 32'h00020000);          // id40 edge
    wr(0, 12'h428, 32'h00003030);          // id40,41 prio 0x30
    wr(0, 12'h42C, 32'h00001000);          // id45 prio 0x10
    wr(0, 12'h828, 32'h00000301);          // id40->cpu0, id41->both
    wr(0, 12'h82C, 32'h00000200);          // id45->cpu1
    wr(0, 12'h104, 32'h00002300);          // enable 40,41,45
    wr(0, 12'h000, 32'h1);

    @(negedge clk); spi[8] = 1'b1;
    @(negedge clk); spi[8] = 1'b0;
    rdchk("R7 edge captured", 0, 12'h204, 32'h00000100);
    rdchk("R12 pending read by cpu1", 1, 12'h204, 32'h00000100);
    chk_req("R10 cpu0 edge req", 0, 1, 40, 8'h30);
    chk_req("R10 cpu1 not targeted", 1, 0, 0, 0);

    wr(0, 12'h000, 32'h0);
    @(negedge clk);
    chk("R8 gate off", 32'(req_valid), 32'h0);
    rdchk("R8 pending kept", 0, 12'h204, 32'h00000100);
    wr(0, 12'h000, 32'h1);

    @(negedge clk); spi[9] = 1'b1;
    @(negedge clk);
    rdchk("R7 level pending", 0, 12'h204, 32'h00000300);
    chk_req("R10 tie lowest id", 0, 1, 40, 8'h30);
    chk_req("R10 cpu1 level", 1, 1, 41, 8'h30);
    spi[13] = 1'b1;
    @(negedge clk);
    chk_req("R10 smaller prio wins", 1, 1, 45, 8'h10);
    chk_req("R10 cpu0 unchanged", 0, 1, 40, 8'h30);

    ack(0, 40);
    rdchk("R7 edge cleared by ack", 0, 12'h204, 32'h00002200);
    chk_req("R10 next candidate", 0, 1, 41, 8'h30);
    ack(0, 41);
    rdchk("R7 level ignores ack", 0, 12'h204, 32'h00002200);
    @(negedge clk); spi[9] = 1'b0;
    @(negedge clk);
    rdchk("R7 level follows input", 0, 12'h204, 32'h00002000);
    chk_req("R10 cpu0 idle", 0, 0, 0, 0);

    // R11: rising edge and acknowledge together
    @(negedge clk); spi[8] = 1'b1; ack_valid = 1'b1; ack_cpu = 1'b0; ack_id = IW'(40);
    @(negedge clk); spi[8] = 1'b0; ack_valid = 1'b0;
    rdchk("R11 edge beats ack", 0, 12'h204, 32'h00002100);
    ack(1, 40);
    rdchk("R7 shared ack from any cpu", 0, 12'h204, 32'h00002000);

    // ---------------- software interrupts and private banking
    wr(0, 12'h100, 32'h00000008);
    wr(1, 12'h100, 32'h00040008);
    wr(0, 12'h400, 32'h05000000);          // id3 prio 5
    rdchk("R4 enable bank cpu0", 0, 12'h100, 32'h00000008);
    rdchk("R4 enable bank cpu1", 1, 12'h100, 32'h00040008);
    wr(0, 12'hF00, 32'h00010003);
    rdchk("R9 sgi on cpu0", 0, 12'h200, 32'h00000008);
    rdchk("R9/R4 sgi not on cpu1", 1, 12'h200, 32'h0);
    chk_req("R9 cpu0 sgi req", 0, 1, 3, 5);
    wr(1, 12'hF00, 32'h00030003);
    rdchk("R9 sgi on cpu1", 1, 12'h200, 32'h00000008);
    chk_req("R10 sgi beats shared", 1, 1, 3, 5);

    ack(0, 3);
    rdchk("R7 sgi acked", 0, 12'h200, 32'h0);
    rdchk("R4 cpu1 copy kept", 1, 12'h200, 32'h00000008);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_cpu = 1'b1; reg_addr = 12'hF00; reg_wdata = 32'h00010003;
    ack_valid = 1'b1; ack_cpu = 1'b0; ack_id = IW'(3);
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; ack_valid = 1'b0;
    rdchk("R11 sgi beats ack", 0, 12'h200, 32'h00000008);

    @(negedge clk); ppi[16 + 2] = 1'b1;
    @(negedge clk);
    rdchk("R7 private level cpu1", 1, 12'h200, 32'h00040008);
    rdchk("R4 private line not on cpu0", 0, 12'h200, 32'h00000008);
    chk_req("R10 private prio 0 wins", 1, 1, 18, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule